// File: doc/BRIEF.md
# Byte Move Instruction Engine

This block runs the byte-move subset of a small accumulator-oriented 8-bit processor. It keeps seven byte registers (A, B, C, D, E, H, L) and a program counter. When it is idle and sees a start pulse, it fetches one opcode from memory at the program counter. It then fetches an operand byte if the opcode needs one and performs at most one data access. Finally it updates the registers or memory and returns to idle.

The engine supports five kinds of transfer: register to register, operand to register, memory to register, register to memory and operand to memory. Memory is one byte wide with a 16-bit address. Data accesses use one of three register pairs as the pointer. Every memory access, whether it fetches an opcode, fetches an operand or moves data, takes one machine cycle of a fixed number of clocks. The cost of an instruction is therefore a multiple of that machine cycle, and the block reports it when the instruction completes. Opcodes outside the group raise a flag and change nothing.

The memory port is synchronous: read data shows the addressed byte one clock after the address appears. The architectural state is brought out so that the surrounding pipeline can inspect it.

Top module: `move8_engine`

## Requirements
- R1: After reset all registers and the program counter read zero, and busy, done, the illegal flag and the write strobe are all low.
- R2: A start pulse while idle raises busy for exactly the reported cost in clocks. Then done pulses for one clock, with the cost and the illegal flag valid in that clock. A start pulse while busy is ignored, and the program counter moves only while busy.
- R3: A machine cycle is 4 clocks. The address is presented in its first clock and held through the cycle. For a store, the write strobe is high only in that first clock. Read data is taken in the last clock. Reported costs are only 4, 8 or 12.
- R4: Opcodes 0x40 to 0x7F (except 0x76) take the destination from bits 5:3 and the source from bits 2:0, with codes B=0, C=1, D=2, E=3, H=4, L=5, memory-at-HL=6, A=7. A move between two registers costs 4 clocks and advances the program counter by 1. Register code k appears on regs_o bits 8k+7:8k, and byte 6 reads zero.
- R5: A move whose source and destination are the same register changes no state and still costs 4 clocks.
- R6: Opcodes with bits 7:6 = 00 and bits 2:0 = 110 whose destination field is not 6 load the following byte into the destination register. They cost 8 clocks and advance the program counter by 2.
- R7: Register pairs place the first-named register in the high byte (HL = {H,L}). Loading a register from memory at HL costs 8 clocks.
- R8: Opcode 0x0A loads A from memory at {B,C}, and opcode 0x1A loads A from memory at {D,E}. Each costs 8 clocks.
- R9: Opcodes 0x70 to 0x75 and 0x77 store the source register to memory at HL, cost 8 clocks and leave the registers unchanged.
- R10: Opcode 0x36 stores the following byte to memory at HL. It costs 12 clocks and advances the program counter by 2.
- R11: Opcode 0x76 and every opcode not covered above raise the illegal flag with done. They change no register and no memory, cost 4 clocks and advance the program counter by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one instruction when idle |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-clock completion pulse |
| cost_o | output | 4 | Clocks spent on the finished instruction |
| illegal_o | output | 1 | Finished opcode was outside the group |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read data, one clock after address |
| pc_o | output | 16 | Program counter |
| regs_o | output | 64 | Register file, byte k = register code k |

## Verification
The hardest situation to reach from the ports is a memory access whose pointer pair holds a value that the bench has arranged. The pair registers can only be set by earlier instructions, so the bench must leave specific bytes in H, L, B, C, D and E first. The stimulus streams operand loads and register moves between the memory accesses. The bench predicts each result from its own copy of the registers and a snapshot of the memory, and it places the opcode and operand bytes just ahead of each start. Further cases are built on purpose: reads whose pointer aliases the opcode byte itself, and a start pulse issued in the middle of an instruction.

// File: rtl/move8_pkg.sv
package move8_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int PTR_W     = 2 * BYTE_W;

    localparam logic [SLOT_W-1:0] SLOT_B   = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_C   = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_D   = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_E   = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_H   = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_L   = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_MEM = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_A   = 3'd7;

    typedef enum logic [2:0] {
        K_RR,
        K_IMM_R,
        K_MEM_R,
        K_REG_M,
        K_IMM_M,
        K_ILL
    } kind_e;

    typedef enum logic [1:0] {
        P_BC,
        P_DE,
        P_HL
    } ptr_e;

    typedef struct packed {
        kind_e             kind;
        logic [SLOT_W-1:0] dst;
        logic [SLOT_W-1:0] src;
        ptr_e              ptr;
    } dec_t;

    typedef enum logic {
        S_IDLE,
        S_RUN
    } state_e;

    typedef enum logic [1:0] {
        PH_OP,
        PH_IMM,
        PH_RD,
        PH_WR
    } phase_e;

endpackage

// File: rtl/move8_decode.sv
module move8_decode
    import move8_pkg::*;
(
    input  logic [BYTE_W-1:0] op_i,
    output dec_t              dec_o
);

    logic [SLOT_W-1:0] f_dst;
    logic [SLOT_W-1:0] f_src;

    assign f_dst = op_i[5:3];
    assign f_src = op_i[2:0];

    always_comb begin
        dec_o.kind = K_ILL;
        dec_o.dst  = f_dst;
        dec_o.src  = f_src;
        dec_o.ptr  = P_HL;
        if (op_i[7:6] == 2'b01) begin
            if (f_dst == SLOT_MEM && f_src == SLOT_MEM) begin
                dec_o.kind = K_ILL;
            end else if (f_src == SLOT_MEM) begin
                dec_o.kind = K_MEM_R;
            end else if (f_dst == SLOT_MEM) begin
                dec_o.kind = K_REG_M;
            end else begin
                dec_o.kind = K_RR;
            end
        end else if (op_i[7:6] == 2'b00 && f_src == 3'b110) begin
            dec_o.kind = (f_dst == SLOT_MEM) ? K_IMM_M : K_IMM_R;
        end else if (op_i == 8'h0A) begin
            dec_o.kind = K_MEM_R;
            dec_o.dst  = SLOT_A;
            dec_o.ptr  = P_BC;
        end else if (op_i == 8'h1A) begin
            dec_o.kind = K_MEM_R;
            dec_o.dst  = SLOT_A;
            dec_o.ptr  = P_DE;
        end
    end

endmodule

// File: rtl/move8_regfile.sv
module move8_regfile
    import move8_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [SLOT_W-1:0]           wr_slot_i,
    input  logic [BYTE_W-1:0]           wr_data_i,
    output logic [NUM_SLOTS*BYTE_W-1:0] slots_o
);

    logic [BYTE_W-1:0] slot_d [NUM_SLOTS];
    logic [BYTE_W-1:0] slot_q [NUM_SLOTS];

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en_i && wr_slot_i != SLOT_MEM) begin
            slot_d[wr_slot_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pack
        if (g == int'(SLOT_MEM)) begin : g_hole
            assign slots_o[g*BYTE_W +: BYTE_W] = '0;
        end else begin : g_reg
            assign slots_o[g*BYTE_W +: BYTE_W] = slot_q[g];
        end
    end

endmodule

// File: rtl/move8_engine.sv
module move8_engine
    import move8_pkg::*;
#(
    parameter int MC_CLKS  = 4,
    parameter int RESET_PC = 0,
    localparam int CNT_W   = $clog2(3 * MC_CLKS + 1),
    localparam int TC_W    = $clog2(MC_CLKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [CNT_W-1:0]            cost_o,
    output logic                        illegal_o,
    output logic [PTR_W-1:0]            mem_addr_o,
    output logic [BYTE_W-1:0]           mem_wdata_o,
    output logic                        mem_we_o,
    input  logic [BYTE_W-1:0]           mem_rdata_i,
    output logic [PTR_W-1:0]            pc_o,
    output logic [NUM_SLOTS*BYTE_W-1:0] regs_o
);

    localparam logic [TC_W-1:0] TC_LAST = TC_W'(MC_CLKS - 1);

    typedef struct packed {
        state_e            state;
        phase_e            phase;
        logic [TC_W-1:0]   tcnt;
        logic [CNT_W-1:0]  cnt;
        dec_t              dec;
        logic [PTR_W-1:0]  pc;
        logic [PTR_W-1:0]  addr;
        logic              we;
        logic [BYTE_W-1:0] wdata;
        logic              done;
        logic [CNT_W-1:0]  cost;
        logic              ill;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    dec_t                        dec_w;
    logic [NUM_SLOTS*BYTE_W-1:0] slots_w;
    logic [BYTE_W-1:0]           slot_val [NUM_SLOTS];
    logic                        rf_we;
    logic [SLOT_W-1:0]           rf_slot;
    logic [BYTE_W-1:0]           rf_data;
    logic [PTR_W-1:0]            ptr_bc, ptr_de, ptr_hl;
    logic [PTR_W-1:0]            ptr_sel;

    move8_decode dec_i (
        .op_i  (mem_rdata_i),
        .dec_o (dec_w)
    );

    move8_regfile rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (rf_we),
        .wr_slot_i (rf_slot),
        .wr_data_i (rf_data),
        .slots_o   (slots_w)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign slot_val[g] = slots_w[g*BYTE_W +: BYTE_W];
    end

    assign ptr_bc = {slot_val[SLOT_B], slot_val[SLOT_C]};
    assign ptr_de = {slot_val[SLOT_D], slot_val[SLOT_E]};
    assign ptr_hl = {slot_val[SLOT_H], slot_val[SLOT_L]};

    always_comb begin
        case (dec_w.ptr)
            P_BC:    ptr_sel = ptr_bc;
            P_DE:    ptr_sel = ptr_de;
            default: ptr_sel = ptr_hl;
        endcase
    end

    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.done = 1'b0;
        rf_we   = 1'b0;
        rf_slot = '0;
        rf_data = '0;

        case (ctl_q.state)
            S_IDLE: begin
                if (start_i) begin
                    ctl_d.state = S_RUN;
                    ctl_d.phase = PH_OP;
                    ctl_d.tcnt  = '0;
                    ctl_d.cnt   = CNT_W'(1);
                    ctl_d.addr  = ctl_q.pc;
                    ctl_d.we    = 1'b0;
                    ctl_d.ill   = 1'b0;
                end
            end
            default: begin
                ctl_d.tcnt = ctl_q.tcnt + TC_W'(1);
                ctl_d.cnt  = ctl_q.cnt + CNT_W'(1);
                ctl_d.we   = 1'b0;
                if (ctl_q.tcnt == TC_LAST) begin
                    ctl_d.tcnt = '0;
                    case (ctl_q.phase)
                        PH_OP: begin
                            ctl_d.pc  = ctl_q.pc + PTR_W'(1);
                            ctl_d.dec = dec_w;
                            case (dec_w.kind)
                                K_RR: begin
                                    rf_we   = 1'b1;
                                    rf_slot = dec_w.dst;
                                    rf_data = slot_val[dec_w.src];
                                    ctl_d.state = S_IDLE;
                                end
                                K_IMM_R, K_IMM_M: begin
                                    ctl_d.phase = PH_IMM;
                                    ctl_d.addr  = ctl_q.pc + PTR_W'(1);
                                end
                                K_MEM_R: begin
                                    ctl_d.phase = PH_RD;
                                    ctl_d.addr  = ptr_sel;
                                end
                                K_REG_M: begin
                                    ctl_d.phase = PH_WR;
                                    ctl_d.addr  = ptr_hl;
                                    ctl_d.we    = 1'b1;
                                    ctl_d.wdata = slot_val[dec_w.src];
                                end
                                default: begin
                                    ctl_d.ill   = 1'b1;
                                    ctl_d.state = S_IDLE;
                                end
                            endcase
                        end
                        PH_IMM: begin
                            ctl_d.pc = ctl_q.pc + PTR_W'(1);
                            if (ctl_q.dec.kind == K_IMM_R) begin
                                rf_we   = 1'b1;
                                rf_slot = ctl_q.dec.dst;
                                rf_data = mem_rdata_i;
                                ctl_d.state = S_IDLE;
                            end else begin
                                ctl_d.phase = PH_WR;
                                ctl_d.addr  = ptr_hl;
                                ctl_d.we    = 1'b1;
                                ctl_d.wdata = mem_rdata_i;
                            end
                        end
                        PH_RD: begin
                            rf_we   = 1'b1;
                            rf_slot = ctl_q.dec.dst;
                            rf_data = mem_rdata_i;
                            ctl_d.state = S_IDLE;
                        end
                        default: begin
                            ctl_d.state = S_IDLE;
                        end
                    endcase
                    if (ctl_d.state == S_IDLE) begin
                        ctl_d.done = 1'b1;
                        ctl_d.cost = ctl_q.cnt;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= S_IDLE;
            ctl_q.phase <= PH_OP;
            ctl_q.pc    <= PTR_W'(RESET_PC);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = (ctl_q.state == S_RUN);
    assign done_o      = ctl_q.done;
    assign cost_o      = ctl_q.cost;
    assign illegal_o   = ctl_q.ill;
    assign mem_addr_o  = ctl_q.addr;
    assign mem_wdata_o = ctl_q.wdata;
    assign mem_we_o    = ctl_q.we;
    assign pc_o        = ctl_q.pc;
    assign regs_o      = slots_w;

endmodule

// File: rtl/move8_checker.sv
module move8_checker #(
    parameter int MC_CLKS = 4,
    parameter int CNT_W   = 4,
    parameter int PTR_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cost,
    input logic             illegal,
    input logic             mem_we,
    input logic [PTR_W-1:0] pc
);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + CNT_W'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_COST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cost == busy_cnt); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(pc)); // R2
    AST_COST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cost == CNT_W'(MC_CLKS) || cost == CNT_W'(2*MC_CLKS)
                  || cost == CNT_W'(3*MC_CLKS))); // R3
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R3
    AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R3
    AST_ILL_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> cost == CNT_W'(MC_CLKS)); // R11

endmodule

bind move8_engine move8_checker #(
    .MC_CLKS (MC_CLKS),
    .CNT_W   (CNT_W),
    .PTR_W   (move8_pkg::PTR_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .done    (done_o),
    .cost    (cost_o),
    .illegal (illegal_o),
    .mem_we  (mem_we_o),
    .pc      (pc_o)
);

// File: tb/move8_engine_tb_top.sv
`timescale 1ns/1ps
module move8_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, illegal, mem_we;
    logic [3:0]  cost;
    logic [15:0] mem_addr, pc;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [63:0] regs;

    logic        lb_en = 1'b0;
    logic [9:0]  lb_a = '0;
    logic [7:0]  lb_d = '0;
    logic [7:0]  mem [1024];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    move8_engine dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .busy_o      (busy),
        .done_o      (done),
        .cost_o      (cost),
        .illegal_o   (illegal),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata),
        .pc_o        (pc),
        .regs_o      (regs)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        else if (lb_en) mem[lb_a] <= lb_d;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    // bench model state
    logic [7:0]  mreg [8];
    logic [15:0] mpc;
    logic [7:0]  e_reg [8];
    logic [15:0] e_pc;
    int          e_cost;
    bit          e_ill, e_wr;
    logic [15:0] e_waddr;
    logic [7:0]  e_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] op);
        if (op[7:6] == 2'b01) begin
            if (op[5:3] == 3'd6 && op[2:0] == 3'd6) return "R11";
            if (op[2:0] == 3'd6) return "R7";
            if (op[5:3] == 3'd6) return "R9";
            if (op[5:3] == op[2:0]) return "R5";
            return "R4";
        end
        if (op[7:6] == 2'b00 && op[2:0] == 3'd6)
            return (op[5:3] == 3'd6) ? "R10" : "R6";
        if (op == 8'h0A || op == 8'h1A) return "R8";
        return "R11";
    endfunction

    task automatic predict(input logic [7:0] op, input logic [7:0] imm);
        logic [15:0] hl, bc, de;
        logic [2:0]  d, s;
        hl = {mreg[4], mreg[5]};
        bc = {mreg[0], mreg[1]};
        de = {mreg[2], mreg[3]};
        d = op[5:3];
        s = op[2:0];
        for (int i = 0; i < 8; i++) e_reg[i] = mreg[i];
        e_pc = mpc + 16'd1; e_cost = 4; e_ill = 0; e_wr = 0;
        e_waddr = '0; e_wdata = '0;
        if (op[7:6] == 2'b01) begin
            if (d == 3'd6 && s == 3'd6) e_ill = 1;
            else if (s == 3'd6) begin e_reg[d] = mem[hl[9:0]]; e_cost = 8; end
            else if (d == 3'd6) begin
                e_wr = 1; e_waddr = hl; e_wdata = mreg[s]; e_cost = 8;
            end else e_reg[d] = mreg[s];
        end else if (op[7:6] == 2'b00 && s == 3'd6) begin
            e_pc = mpc + 16'd2;
            if (d == 3'd6) begin
                e_wr = 1; e_waddr = hl; e_wdata = imm; e_cost = 12;
            end else begin e_reg[d] = imm; e_cost = 8; end
        end else if (op == 8'h0A) begin e_reg[7] = mem[bc[9:0]]; e_cost = 8; end
        else if (op == 8'h1A) begin e_reg[7] = mem[de[9:0]]; e_cost = 8; end
        else e_ill = 1;
    endtask

    task automatic load2(input logic [15:0] a, input logic [7:0] b0, input logic [7:0] b1);
        @(negedge clk);
        lb_en = 1; lb_a = a[9:0]; lb_d = b0;
        @(negedge clk);
        lb_a = a[9:0] + 10'd1; lb_d = b1;
        @(negedge clk);
        lb_en = 0;
    endtask

    task automatic run(input logic [7:0] op, input logic [7:0] imm, input bit poke);
        string r;
        int n;
        bit hung;
        r = req_of(op);
        load2(mpc, op, imm);
        predict(op, imm);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        n = 0; hung = 0;
        while (!done) begin
            if (busy) n++;
            if (poke && n == 2) start = 1; else start = 0;
            if (n > 40) begin hung = 1; break; end
            @(negedge clk);
        end
        start = 0;
        if (hung) begin
            chk(0, "R2", "watchdog no done", 0, 1);
            return;
        end
        chk(cost == 4'(e_cost), r, "cost", cost, e_cost);
        chk(n == e_cost, "R2", "busy clocks", n, e_cost);
        chk(illegal == e_ill, r, "illegal flag", illegal, e_ill);
        chk(pc == e_pc, r, "pc", pc, e_pc);
        for (int i = 0; i < 8; i++)
            chk(regs[i*8 +: 8] == e_reg[i], r, $sformatf("reg code %0d", i),
                regs[i*8 +: 8], e_reg[i]);
        if (e_wr)
            chk(mem[e_waddr[9:0]] == e_wdata, r, "memory byte",
                mem[e_waddr[9:0]], e_wdata);
        for (int i = 0; i < 8; i++) mreg[i] = e_reg[i];
        mpc = e_pc;
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(!busy && pc == e_pc, "R2", "start while busy ignored",
                {busy, pc}, {1'b0, e_pc});
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        mpc = '0;
        void'($urandom(32'd1337));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(regs == 64'h0 && pc == 16'h0, "R1", "reset state", {regs[47:0], pc}, 0);
        chk(!busy && !done && !illegal && !mem_we, "R1", "reset controls",
            {busy, done, illegal, mem_we}, 0);

        // directed corner cases
        run(8'h06, 8'h12, 0);  // R6 B
        run(8'h0E, 8'h34, 0);  // R6 C
        run(8'h16, 8'h01, 0);  // R6 D
        run(8'h1E, 8'h80, 0);  // R6 E
        run(8'h26, 8'h02, 0);  // R6 H
        run(8'h2E, 8'h10, 0);  // R6 L
        run(8'h3E, 8'hA5, 0);  // R6 A
        run(8'h41, 8'h00, 0);  // R4 B<-C
        run(8'h6F, 8'h00, 0);  // R4 L<-A
        run(8'h49, 8'h00, 0);  // R5 self move
        run(8'h7F, 8'h00, 0);  // R5 self move on A
        run(8'h0A, 8'h00, 0);  // R8 via BC
        run(8'h1A, 8'h00, 0);  // R8 via DE
        run(8'h7E, 8'h00, 0);  // R7 from HL
        run(8'h70, 8'h00, 0);  // R9 store B
        run(8'h77, 8'h00, 0);  // R9 store A
        run(8'h36, 8'h5C, 0);  // R10 store operand
        run(8'h46, 8'h00, 0);  // R7 read back
        run(8'h76, 8'h00, 0);  // R11 halt code is illegal here
        run(8'hFF, 8'h00, 0);  // R11 outside group
        run(8'h36, 8'h99, 1);  // R2 start during busy
        run(8'h2E, 8'h00, 0);  // R7 HL aliases program bytes
        run(8'h26, 8'h00, 0);
        run(8'h7E, 8'h00, 0);

        for (int k = 0; k < 400; k++) begin
            logic [7:0] op;
            int sel;
            sel = int'($urandom % 4);
            if (sel < 2) op = 8'h40 | 8'($urandom % 64);
            else if (sel == 2) op = {2'b00, 3'($urandom % 8), 3'b110};
            else op = 8'($urandom);
            if (k % 50 == 0) op = 8'h0A;
            if (k % 50 == 25) op = 8'h1A;
            run(op, 8'($urandom), (k % 97) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R2 global watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule